// File: doc/BRIEF.md
# Carry-Select Logic Element Group

A row of identical logic elements that share one set of mode and register controls. In logic mode each element works on its own four inputs through a 16-entry truth table and can produce any function of them. In arithmetic mode each element splits into four two-input functions. Two of them produce the element's sum bit under both carry assumptions, and the other two produce the carry-outs that go with those sums.

The carry-outs travel along two parallel chains that run the length of the row. One chain starts from carry 0 and the other from carry 1. The real carry-in of the row only picks between the two precomputed answers, so it never has to ripple through the row. One shared control switches the whole row between addition and subtraction. Subtraction inverts operand B and forces the row's carry-in to 1.

Each element ends in a register. The register has asynchronous clear and load, synchronous clear and load, and a clock enable. The synchronous load takes the register of the element below, so the row can also shift its stored value.

Top module: `le_group`

## Requirements
- R1: In logic mode (`mode_i`=0), `comb_o[k]` equals bit `{d_i[k],c_i[k],b_i[k],a_i[k]}` of the 16-bit slice `lut_mask_i[16k+15:16k]`.
- R2: In arithmetic mode (`mode_i`=1) with `sub_i`=0, `{cout_o,comb_o}` equals `a_i + b_i + cin_i` with no register delay.
- R3: In arithmetic mode with `sub_i`=1, `comb_o` equals `a_i - b_i` modulo 2^WIDTH and `cin_i` has no effect. `cout_o` is 1 exactly when `a_i >= b_i` unsigned.
- R4: The carry-in selects between two precomputed results. In addition, raising `cin_i` raises `{cout_o,comb_o}` by exactly one. Along the row, the carry computed under the 0 assumption never exceeds the carry computed under the 1 assumption.
- R5: While `rst_ni` is low, `q_o` is all zeros.
- R6: At a clock edge with `ena_i`=1 and no other register control active, `q_o` takes `comb_o`. With `ena_i`=0, `q_o` holds its value.
- R7: At an enabled edge with `sclr_i`=1, `q_o` becomes 0 even when `sload_i` is also 1.
- R8: At an enabled edge with `sload_i`=1 and `sclr_i`=0, `q_o[k]` takes `q_o[k-1]` and `q_o[0]` takes `chain_i`. `chain_o` always equals `q_o[WIDTH-1]`.
- R9: A rising `aload_i` copies `adata_i` into `q_o` without a clock edge. While it stays high, clock edges keep `q_o` at `adata_i`.
- R10: A high `aclr_i` clears `q_o` at once and overrides `aload_i`.
- R11: With `ena_i`=0, `sclr_i` and `sload_i` leave `q_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Register clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mode_i | input | 1 | 0 logic mode, 1 arithmetic mode |
| sub_i | input | 1 | Arithmetic: 0 add, 1 subtract |
| cin_i | input | 1 | Row carry-in for addition |
| lut_mask_i | input | 16*WIDTH | Truth tables, 16 bits per element |
| a_i | input | WIDTH | Input a per element / operand A |
| b_i | input | WIDTH | Input b per element / operand B |
| c_i | input | WIDTH | Input c per element (logic mode) |
| d_i | input | WIDTH | Input d per element (logic mode) |
| ena_i | input | 1 | Clock enable for all synchronous actions |
| sclr_i | input | 1 | Synchronous clear |
| sload_i | input | 1 | Synchronous shift-load from the register chain |
| aclr_i | input | 1 | Asynchronous clear |
| aload_i | input | 1 | Asynchronous load |
| adata_i | input | WIDTH | Data for asynchronous load |
| chain_i | input | 1 | Register chain input to element 0 |
| comb_o | output | WIDTH | Combinational result per element |
| cout_o | output | 1 | Row carry-out |
| q_o | output | WIDTH | Register outputs |
| chain_o | output | 1 | Register chain output of the top element |

## Verification
A fault in either carry chain shows up on `comb_o` and `cout_o` in the same cycle as the operands. It only shows for carry-in values and operand pairs whose carry runs through the broken position, so the vectors include full-length carry runs, borrows, and pairs that differ only in carry-in. A wrong priority among the register controls surfaces on `q_o` one edge after the conflicting controls, or at once for the asynchronous ones. The bench therefore sets up each conflict on purpose and samples right after the edge or the asynchronous change.

// File: rtl/le_pkg.sv
package le_pkg;
  localparam int unsigned LUT_INPUTS = 4;
  localparam int unsigned LUT_SIZE   = 1 << LUT_INPUTS;

  typedef enum logic {
    MODE_LOGIC = 1'b0,
    MODE_ARITH = 1'b1
  } le_mode_e;

  typedef struct packed {
    logic sum0;
    logic sum1;
    logic co0;
    logic co1;
  } arith_t;
endpackage

// File: rtl/le_lut.sv
module le_lut #(
  parameter int unsigned N = le_pkg::LUT_INPUTS,
  localparam int unsigned SIZE = 1 << N
) (
  input  logic [SIZE-1:0] mask_i,
  input  logic [N-1:0]    sel_i,
  output logic            f_o
);
  assign f_o = mask_i[sel_i];
endmodule

// File: rtl/le_arith.sv
module le_arith (
  input  logic           a_i,
  input  logic           b_i,
  input  logic           sub_i,
  input  logic           c0_i,
  input  logic           c1_i,
  output le_pkg::arith_t res_o
);
  logic b_eff, prop, gen;

  assign b_eff = b_i ^ sub_i;
  assign prop  = a_i ^ b_eff;
  assign gen   = a_i & b_eff;

  // four two-input functions: sums and carries under both assumptions
  assign res_o.sum0 = prop ^ c0_i;
  assign res_o.sum1 = prop ^ c1_i;
  assign res_o.co0  = gen | (prop & c0_i);
  assign res_o.co1  = gen | (prop & c1_i);
endmodule

// File: rtl/le_reg.sv
module le_reg (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic aclr_i,
  input  logic aload_i,
  input  logic adata_i,
  input  logic ena_i,
  input  logic sclr_i,
  input  logic sload_i,
  input  logic chain_i,
  input  logic d_i,
  output logic q_o
);
  logic clr_n;
  assign clr_n = rst_ni & ~aclr_i;

  always_ff @(posedge clk_i or negedge clr_n or posedge aload_i) begin
    if (!clr_n)        q_o <= 1'b0;
    else if (aload_i)  q_o <= adata_i;
    else if (ena_i) begin
      if (sclr_i)       q_o <= 1'b0;
      else if (sload_i) q_o <= chain_i;
      else              q_o <= d_i;
    end
  end

  // R10
  aclr_zero_chk: assert property (@(posedge clk_i) !clr_n |-> (q_o == 1'b0));

  // R7
  sclr_zero_chk: assert property (@(posedge clk_i) disable iff (!clr_n)
    (ena_i && sclr_i && !aload_i) |=> (aload_i || q_o == 1'b0));

  // R11
  hold_chk: assert property (@(posedge clk_i) disable iff (!clr_n)
    (!ena_i && !aload_i) |=> (aload_i || $stable(q_o)));

  // R8
  shift_load_chk: assert property (@(posedge clk_i) disable iff (!clr_n)
    (ena_i && !sclr_i && sload_i && !aload_i) |=> (aload_i || q_o == $past(chain_i)));
endmodule

// File: rtl/le_cell.sv
module le_cell
  import le_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  le_mode_e            mode_i,
  input  logic                sub_i,
  input  logic                sel_i,
  input  logic [LUT_SIZE-1:0] mask_i,
  input  logic [3:0]          in_i,
  input  logic                c0_i,
  input  logic                c1_i,
  input  logic                ena_i,
  input  logic                sclr_i,
  input  logic                sload_i,
  input  logic                aclr_i,
  input  logic                aload_i,
  input  logic                adata_i,
  input  logic                chain_i,
  output logic                comb_o,
  output logic                co0_o,
  output logic                co1_o,
  output logic                q_o
);
  logic   lut_f;
  arith_t ar;

  le_lut #(.N(LUT_INPUTS)) i_lut (
    .mask_i (mask_i),
    .sel_i  (in_i),
    .f_o    (lut_f)
  );

  le_arith i_arith (
    .a_i   (in_i[0]),
    .b_i   (in_i[1]),
    .sub_i (sub_i),
    .c0_i  (c0_i),
    .c1_i  (c1_i),
    .res_o (ar)
  );

  assign co0_o  = ar.co0;
  assign co1_o  = ar.co1;
  assign comb_o = (mode_i == MODE_ARITH) ? (sel_i ? ar.sum1 : ar.sum0) : lut_f;

  le_reg i_reg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .aclr_i  (aclr_i),
    .aload_i (aload_i),
    .adata_i (adata_i),
    .ena_i   (ena_i),
    .sclr_i  (sclr_i),
    .sload_i (sload_i),
    .chain_i (chain_i),
    .d_i     (comb_o),
    .q_o     (q_o)
  );
endmodule

// File: rtl/le_group.sv
module le_group
  import le_pkg::*;
#(
  parameter int unsigned WIDTH = 4,
  localparam int unsigned MASK_W = WIDTH * LUT_SIZE
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_i,
  input  logic              sub_i,
  input  logic              cin_i,
  input  logic [MASK_W-1:0] lut_mask_i,
  input  logic [WIDTH-1:0]  a_i,
  input  logic [WIDTH-1:0]  b_i,
  input  logic [WIDTH-1:0]  c_i,
  input  logic [WIDTH-1:0]  d_i,
  input  logic              ena_i,
  input  logic              sclr_i,
  input  logic              sload_i,
  input  logic              aclr_i,
  input  logic              aload_i,
  input  logic [WIDTH-1:0]  adata_i,
  input  logic              chain_i,
  output logic [WIDTH-1:0]  comb_o,
  output logic              cout_o,
  output logic [WIDTH-1:0]  q_o,
  output logic              chain_o
);
  logic [WIDTH:0] c0, c1, rc;
  logic           sel;
  le_mode_e       mode;

  assign mode  = le_mode_e'(mode_i);
  assign sel   = sub_i | cin_i;   // subtraction forces carry-in 1
  assign c0[0] = 1'b0;
  assign c1[0] = 1'b1;
  assign rc[0] = chain_i;

  for (genvar k = 0; k < WIDTH; k++) begin : g_cell
    le_cell i_cell (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .mode_i  (mode),
      .sub_i   (sub_i),
      .sel_i   (sel),
      .mask_i  (lut_mask_i[k*LUT_SIZE +: LUT_SIZE]),
      .in_i    ({d_i[k], c_i[k], b_i[k], a_i[k]}),
      .c0_i    (c0[k]),
      .c1_i    (c1[k]),
      .ena_i   (ena_i),
      .sclr_i  (sclr_i),
      .sload_i (sload_i),
      .aclr_i  (aclr_i),
      .aload_i (aload_i),
      .adata_i (adata_i[k]),
      .chain_i (rc[k]),
      .comb_o  (comb_o[k]),
      .co0_o   (c0[k+1]),
      .co1_o   (c1[k+1]),
      .q_o     (q_o[k])
    );
    assign rc[k+1] = q_o[k];

    // R4
    carry_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      c0[k+1] |-> c1[k+1]);
  end

  assign cout_o  = sel ? c1[WIDTH] : c0[WIDTH];
  assign chain_o = rc[WIDTH];

  // R2
  add_sum_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i && !sub_i) |->
      ({cout_o, comb_o} == ({1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, cin_i})));
endmodule

// File: tb/test_le_group.sv
module test_le_group;
  localparam int W = 4;
  localparam time CLK = 5ns;

  logic clk = 0, rst_ni = 0;
  logic mode, sub, cin, ena, sclr, sload, aclr, aload, chain;
  logic [W*16-1:0] mask;
  logic [W-1:0] a, b, c, d, adata, comb, q;
  logic cout, chain_o;

  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK/2) clk = ~clk;

  le_group #(.WIDTH(W)) i_le_group (
    .clk_i(clk), .rst_ni(rst_ni), .mode_i(mode), .sub_i(sub), .cin_i(cin),
    .lut_mask_i(mask), .a_i(a), .b_i(b), .c_i(c), .d_i(d), .ena_i(ena),
    .sclr_i(sclr), .sload_i(sload), .aclr_i(aclr), .aload_i(aload),
    .adata_i(adata), .chain_i(chain), .comb_o(comb), .cout_o(cout),
    .q_o(q), .chain_o(chain_o)
  );

  // {sub, cin, a, b, expected {cout,sum}}
  localparam logic [14:0] VEC [10] = '{
    {1'b0, 1'b0, 4'h3, 4'h5, 5'h08},
    {1'b0, 1'b1, 4'h7, 4'h8, 5'h10},
    {1'b0, 1'b0, 4'hF, 4'h1, 5'h10},
    {1'b0, 1'b1, 4'hF, 4'hF, 5'h1F},
    {1'b0, 1'b0, 4'h0, 4'h0, 5'h00},
    {1'b1, 1'b0, 4'h9, 4'h3, 5'h16},
    {1'b1, 1'b0, 4'h3, 4'h9, 5'h0A},
    {1'b1, 1'b1, 4'h5, 4'h5, 5'h10},
    {1'b1, 1'b0, 4'h0, 4'h1, 5'h0F},
    {1'b1, 1'b1, 4'hF, 4'h0, 5'h1F}
  };

  localparam logic [15:0] MASKS [4] = '{16'h8000, 16'h6996, 16'hFFFE, 16'hCAFE};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  initial begin
    #(CLK * 100000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [4:0] r0;
    mode = 1; sub = 0; cin = 0; ena = 0; sclr = 0; sload = 0; aclr = 0;
    aload = 0; chain = 0; a = 0; b = 0; c = 0; d = 0; adata = 0;
    for (int k = 0; k < W; k++) mask[k*16 +: 16] = MASKS[k];

    #(CLK*2);
    chk("R5 reset", 32'(q), 32'h0);
    @(negedge clk); rst_ni = 1;

    // R2 R3 vectors
    for (int i = 0; i < 10; i++) begin
      {sub, cin, a, b} = VEC[i][14:5];
      #1;
      chk(VEC[i][14] ? "R3 sub" : "R2 add", 32'({cout, comb}), 32'(VEC[i][4:0]));
    end

    // R4: carry-in selects a result exactly one higher
    sub = 0;
    for (int i = 0; i < 4; i++) begin
      a = 4'(i * 5 + 3); b = 4'(i * 3 + 12);
      cin = 0; #1; r0 = {cout, comb};
      cin = 1; #1;
      chk("R4 carry select", 32'({cout, comb}), 32'(r0 + 5'd1));
    end

    // R1 logic mode, all 16 input patterns
    mode = 0;
    for (int n = 0; n < 16; n++) begin
      a = {W{n[0]}}; b = {W{n[1]}}; c = {W{n[2]}}; d = {W{n[3]}};
      #1;
      for (int k = 0; k < W; k++) chk("R1 lut", 32'(comb[k]), 32'(MASKS[k][n]));
    end

    // register behaviour, arithmetic add
    mode = 1; sub = 0; cin = 0; c = 0; d = 0;
    a = 4'h3; b = 4'h5; ena = 1;
    tick();
    chk("R6 capture", 32'(q), 32'h8);
    ena = 0; a = 4'h1; b = 4'h1;
    tick();
    chk("R6 hold", 32'(q), 32'h8);
    sclr = 1;
    tick();
    chk("R11 sclr gated", 32'(q), 32'h8);
    sclr = 0; sload = 1; chain = 1;
    tick();
    chk("R11 sload gated", 32'(q), 32'h8);
    ena = 1;
    tick();
    chk("R8 shift", 32'(q), 32'h1);
    tick();
    chk("R8 shift", 32'(q), 32'h3);
    chain = 0;
    tick(); tick();
    chk("R8 shift", 32'(q), 32'hC);
    chk("R8 chain out", 32'(chain_o), 32'h1);
    sclr = 1;
    tick();
    chk("R7 sclr over sload", 32'(q), 32'h0);
    chk("R8 chain out", 32'(chain_o), 32'h0);
    sclr = 0; sload = 0;

    // asynchronous controls
    adata = 4'hA;
    #1 aload = 1;
    #1 chk("R9 async load", 32'(q), 32'hA);
    a = 4'h2; b = 4'h2;
    tick();
    chk("R9 load held over capture", 32'(q), 32'hA);
    #1 aclr = 1;
    #1 chk("R10 clear over load", 32'(q), 32'h0);
    tick();
    chk("R10 clear held", 32'(q), 32'h0);
    aclr = 0; aload = 0; ena = 0;
    tick();
    chk("R6 hold after async", 32'(q), 32'h0);
    ena = 1; sub = 1; a = 4'h2; b = 4'h7;
    tick();
    chk("R6 capture sub", 32'(q), 32'hB);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule